// File: doc/BRIEF.md
# Timer Input Glitch Filter

This block cleans up one external timer input before a capture stage uses it. The raw pin is first brought into the clock domain by a chain of flip-flops. A strobe derived from the master clock then samples the result. The filtered level changes only after a required number of consecutive strobed samples have shown the opposite level. A 4-bit setting picks both the strobe rate and that required count from a fixed sixteen-entry table, so one control field covers the range from "pass straight through" to "reject anything shorter than a few hundred clocks".

Next to the filtered level, the block issues a one-cycle rising pulse and a one-cycle falling pulse whenever that level changes. The capture stage can use these pulses directly. The setting is meant to be changed only while the block is held in reset or while the input is idle. The strobe divider runs freely from the moment reset is released.

Top module: `timer_input_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the filtered level is 0 and both edge pulses are 0.
- R2: The raw input passes through a two-flop synchronizer. With setting 0, a raw change driven between edges k-1 and k appears on the filtered level right after edge k+2.
- R3: The sample strobe fires on every D-th clock edge after reset release, counted from the first edge as edge 1. D is 1 for settings 0 to 3, 2 for 4 and 5, 4 for 6 and 7, 8 for 8 and 9, 16 for 10 to 12, and 32 for 13 to 15.
- R4: The required run length N is as follows. Setting 0 uses N = 1, which means no filtering. Settings 1, 2 and 3 use N = 2, 4 and 8. Settings 4, 6 and 8 use N = 6, and settings 5, 7 and 9 use N = 8. Settings 10 and 13 use N = 5, settings 11 and 14 use N = 6, and settings 12 and 15 use N = 8.
- R5: The filtered level takes a new value only on the strobe on which the N-th consecutive strobed sample differing from the current level is seen.
- R6: A strobed sample equal to the current filtered level restarts the count. An input excursion covering fewer than N strobes therefore leaves the level unchanged.
- R7: The rising pulse is high for exactly the one cycle in which the filtered level first reads 1 after reading 0.
- R8: The falling pulse is high for exactly the one cycle in which the filtered level first reads 0 after reading 1. The two pulses are never high together.
- R9: The filtered level never changes except right after a strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 4 | Filter setting, selects divider and run length |
| raw_i | input | 1 | Unsynchronized timer input |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-cycle pulse on a 0-to-1 filtered change |
| fall_o | output | 1 | One-cycle pulse on a 1-to-0 filtered change |

## Verification
The hardest case to reach from the ports is an excursion that lasts exactly one strobe less, or exactly one strobe more, than the run length. Whether such an excursion is accepted depends on where the divider phase falls relative to the input edge. To cover this, every setting is driven with pulse widths derived from its own D and N: one less than N·D, N·D plus a margin, and very short glitches. A reference model in the bench tracks the divider phase from reset release. It predicts the exact cycle of every edge pulse, and the scoreboard matches each pulse from the design against that prediction.

// File: rtl/tfilt_pkg.sv
package tfilt_pkg;

   typedef struct packed {
      logic [2:0] div_exp;   // strobe every 2**div_exp clocks
      logic [3:0] run_len;   // consecutive agreeing samples required
   } tf_setting_t;

   function automatic tf_setting_t tf_decode(input logic [3:0] code);
      tf_setting_t s;
      case (code)
         4'd0:    s = '{3'd0, 4'd1};
         4'd1:    s = '{3'd0, 4'd2};
         4'd2:    s = '{3'd0, 4'd4};
         4'd3:    s = '{3'd0, 4'd8};
         4'd4:    s = '{3'd1, 4'd6};
         4'd5:    s = '{3'd1, 4'd8};
         4'd6:    s = '{3'd2, 4'd6};
         4'd7:    s = '{3'd2, 4'd8};
         4'd8:    s = '{3'd3, 4'd6};
         4'd9:    s = '{3'd3, 4'd8};
         4'd10:   s = '{3'd4, 4'd5};
         4'd11:   s = '{3'd4, 4'd6};
         4'd12:   s = '{3'd4, 4'd8};
         4'd13:   s = '{3'd5, 4'd5};
         4'd14:   s = '{3'd5, 4'd6};
         default: s = '{3'd5, 4'd8};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tfilt_sync.sv
module tfilt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tfilt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

   // R2
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_q[0]) |=> chain_q[1]);
endmodule

// File: rtl/tfilt_tick.sv
module tfilt_tick #(
   parameter int EXP_W = 3,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);
   localparam int MAX_EXP = (1 << EXP_W) - 1;

   generate
      if (CNT_W < 1 || CNT_W > MAX_EXP) begin : g_bad
         $error("tfilt_tick: CNT_W must fit the exponent range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;

   always_comb begin
      mask = '0;
      for (int i = 0; i < CNT_W; i++) begin
         if (i < int'(exp_i)) mask[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = ((cnt_q & mask) == mask);

   // R3
   full_rate_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_i == '0) |-> tick_o);
   // R3
   half_rate_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_i == EXP_W'(1) && $past(exp_i) == EXP_W'(1) && tick_o) |=> !tick_o);
endmodule

// File: rtl/tfilt_run.sv
module tfilt_run #(
   parameter int  RUN_W     = 4,
   parameter logic RST_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             smp_i,
   input  logic [RUN_W-1:0] run_len_i,
   output logic             level_o,
   output logic             rise_o,
   output logic             fall_o
);
   generate
      if (RUN_W < 4) begin : g_bad
         $error("tfilt_run: RUN_W must hold a run length of 8");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic [RUN_W:0]   run_next;
   logic             differ;
   logic             accept;

   assign differ   = (smp_i != level_o);
   assign run_next = {1'b0, run_q} + 1'b1;
   assign accept   = tick_i && differ && (run_next >= {1'b0, run_len_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         level_o <= RST_LEVEL;
         rise_o  <= 1'b0;
         fall_o  <= 1'b0;
      end else begin
         rise_o <= 1'b0;
         fall_o <= 1'b0;
         if (tick_i) begin
            if (!differ) begin
               run_q <= '0;
            end else if (accept) begin
               run_q   <= '0;
               level_o <= smp_i;
               rise_o  <= smp_i;
               fall_o  <= !smp_i;
            end else begin
               run_q <= run_next[RUN_W-1:0];
            end
         end
      end
   end

   // R9
   level_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> $past(tick_i));
   // R7
   rise_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> (level_o && !$past(level_o)));
   // R8
   fall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> (!level_o && $past(level_o)));
   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !differ) |=> (level_o == $past(level_o)));
endmodule

// File: rtl/timer_input_filter.sv
module timer_input_filter #(
   parameter int   CFG_W       = 4,
   parameter int   SYNC_STAGES = 2,
   parameter int   DIV_CNT_W   = 5,
   parameter int   RUN_W       = 4,
   parameter logic RST_LEVEL   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_i,
   input  logic             raw_i,
   output logic             level_o,
   output logic             rise_o,
   output logic             fall_o
);
   import tfilt_pkg::*;

   localparam int EXP_W = 3;

   generate
      if (CFG_W != 4) begin : g_bad_cfg
         $error("timer_input_filter: setting table needs CFG_W of 4");
      end
   endgenerate

   tf_setting_t setting;
   logic        synced;
   logic        tick;

   assign setting = tf_decode(cfg_i);

   tfilt_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_i),
      .q_o   (synced)
   );

   tfilt_tick #(.EXP_W(EXP_W), .CNT_W(DIV_CNT_W)) tick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .exp_i  (setting.div_exp),
      .tick_o (tick)
   );

   tfilt_run #(.RUN_W(RUN_W), .RST_LEVEL(RST_LEVEL)) run_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .smp_i     (synced),
      .run_len_i (RUN_W'(setting.run_len)),
      .level_o   (level_o),
      .rise_o    (rise_o),
      .fall_o    (fall_o)
   );

   // R8
   one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o));
   // R5
   change_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> (rise_o || fall_o));
   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: tb/timer_input_filter_tb.sv
module timer_input_filter_tb_top;
   logic       clk;
   logic       rst_n;
   logic [3:0] cfg;
   logic       raw;
   logic       level, rise, fall;

   int n_checks = 0;
   int n_fail   = 0;

   timer_input_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .raw_i(raw),
      .level_o(level), .rise_o(rise), .fall_o(fall)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   typedef struct { bit up; int cyc; } ev_t;
   ev_t sb_q[$];

   int gcyc = 0;
   int m_d = 1, m_n = 1;
   bit m_s1, m_s2, m_lvl;
   int m_run, m_cyc;
   int lvl_bad;

   // R3 R4 table from the requirements
   function automatic void tbl(input int code, output int d, output int n);
      case (code)
         0: begin d = 1;  n = 1; end
         1: begin d = 1;  n = 2; end
         2: begin d = 1;  n = 4; end
         3: begin d = 1;  n = 8; end
         4: begin d = 2;  n = 6; end
         5: begin d = 2;  n = 8; end
         6: begin d = 4;  n = 6; end
         7: begin d = 4;  n = 8; end
         8: begin d = 8;  n = 6; end
         9: begin d = 8;  n = 8; end
         10: begin d = 16; n = 5; end
         11: begin d = 16; n = 6; end
         12: begin d = 16; n = 8; end
         13: begin d = 32; n = 5; end
         14: begin d = 32; n = 6; end
         default: begin d = 32; n = 8; end
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, gcyc);
      end
   endtask

   // reference model, scoreboard driver side
   always @(posedge clk) begin
      gcyc++;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_cyc = 0;
      end else begin
         m_cyc++;
         if (m_cyc % m_d == 0) begin
            if (m_s2 != m_lvl) begin
               if (m_run + 1 >= m_n) begin
                  m_lvl = m_s2;
                  m_run = 0;
                  sb_q.push_back('{m_s2, gcyc});
               end else m_run++;
            end else m_run = 0;
         end
         m_s2 = m_s1;
         m_s1 = raw;
      end
   end

   // monitor side
   always @(negedge clk) begin
      if (rst_n) begin
         if (level !== m_lvl) lvl_bad++;
         if (rise || fall) begin
            if (sb_q.size() == 0) begin
               check("R9 unexpected pulse", 1, 0);
            end else begin
               ev_t e;
               e = sb_q.pop_front();
               if (e.up) check("R7 rise pulse", rise, 1);
               else      check("R8 fall pulse", fall, 1);
               check("R3 R4 R5 pulse cycle", gcyc, e.cyc);
               check("R8 pulses exclusive", int'(rise && fall), 0);
            end
         end
      end
   end

   task automatic do_reset(input int code);
      @(negedge clk);
      rst_n = 1'b0;
      raw   = 1'b0;
      cfg   = 4'(code);
      tbl(code, m_d, m_n);
      repeat (2) @(negedge clk);
      check("R1 reset level", level, 0);
      check("R1 reset pulses", int'(rise) + int'(fall), 0);
      rst_n = 1'b1;
      lvl_bad = 0;
      @(negedge clk);
      check("R1 level after release", level, 0);
   endtask

   task automatic hold(input bit v, input int w);
      raw = v;
      repeat (w) @(negedge clk);
   endtask

   bit done = 0;

   initial begin
      rst_n = 1'b1;
      raw   = 1'b0;
      cfg   = 4'd0;
      // R2 synchronizer latency with no filtering
      do_reset(0);
      raw = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R2 not yet through", level, 0);
      @(negedge clk);
      check("R2 through after 3 edges", level, 1);
      hold(1'b0, 6);
      // R6 glitch shorter than run length, setting 3 (D=1, N=8)
      do_reset(3);
      hold(1'b1, 5);
      hold(1'b0, 12);
      check("R6 short glitch ignored", level, 0);
      hold(1'b1, 7);
      hold(1'b0, 1);
      hold(1'b1, 7);
      hold(1'b0, 12);
      check("R6 interrupted run ignored", level, 0);
      check("R6 level matches model", lvl_bad, 0);
      // sweep every setting with widths around the threshold
      for (int c = 0; c < 16; c++) begin
         int d, n;
         tbl(c, d, n);
         do_reset(c);
         hold(1'b1, d * n + 3 * d);
         hold(1'b0, d * n - d);
         hold(1'b1, 1);
         hold(1'b0, d * (n + 2));
         hold(1'b1, 2);
         hold(1'b0, 3);
         hold(1'b1, d * n - 1);
         hold(1'b0, d * (n + 2));
         hold(1'b1, 3 * d * n);
         hold(1'b0, d * (n + 3));
         check($sformatf("R5 level tracks model, setting %0d", c), lvl_bad, 0);
         check("R5 queue drained", sb_q.size(), 0);
         sb_q.delete();
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         check("watchdog expired", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule